// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block gathers sixteen interrupt request lines and presents one interrupt output to a processor. It is built from two eight-input stages. Lines 0 to 7 enter the primary stage and lines 8 to 15 enter the secondary stage. The secondary stage reports into input 2 of the primary, so input 2 is never a device source. A device request on legacy line 2 is steered onto secondary line 9, and the two behave as one source.

Requests are latched into a pending register. When the processor acknowledges, the best pending line moves into an in-service register and the block returns an 8-bit vector number. The processor uses that number to index its handler table. A request that outranks every level in service raises the interrupt again, so handlers can nest. Weaker requests wait. An end-of-service pulse retires the strongest active level.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, `cpu_int` and `vec_valid` are low, and no line is pending or in service.
- R2: An edge that samples a request line high latches it as pending. `cpu_int` is high in the cycle after that edge. The latch holds after the request drops, until the line is acknowledged.
- R3: Lines rank from strongest to weakest as 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. An acknowledge services the strongest unmasked pending line.
- R4: An edge that samples `ack` high while `cpu_int` is high makes `vec_valid` high for the next cycle. In that same cycle, `vec` equals `{base[7:3], line[2:0]}`. `base` is `base_pri` for lines 0–7 and `base_sec` for lines 8–15, and bits [2:0] of each base are ignored.
- R5: A request on line 2 is treated as line 9. It is acknowledged with the secondary vector for offset 1, and no vector for primary offset 2 is ever produced.
- R6: A line whose `mask` bit is 1 may still latch as pending. It does not assert `cpu_int` and is not acknowledged. Once unmasked, it is serviced as normal.
- R7: With levels in service, `cpu_int` is high only when an unmasked pending line ranks strictly above every in-service level. Any secondary level in service also blocks lines 3–7.
- R8: An edge that samples `eos` high clears the strongest in-service level. Pending lines that were held off by that level then raise `cpu_int` in the next cycle.
- R9: An `ack` sampled while `cpu_int` is low is ignored: no vector is produced and the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Per-line request levels |
| mask | input | 16 | Per-line mask, 1 = blocked |
| base_pri | input | 8 | Vector base, primary stage (bits [7:3] used) |
| base_sec | input | 8 | Vector base, secondary stage (bits [7:3] used) |
| ack | input | 1 | Processor acknowledge |
| eos | input | 1 | End of service |
| cpu_int | output | 1 | Interrupt to processor |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec | output | 8 | Vector number |

## Verification
`cpu_int` is a combinational function of the pending and in-service registers, so it reflects a request, acknowledge or end of service one edge after the stimulus. `vec_valid` and `vec` are registered and are valid exactly in the cycle after the acknowledging edge. The bench changes inputs only at falling edges and compares every output at the next falling edge. Each comparison therefore sees the state left by exactly one rising edge. This holds both for the directed corner cases and for a long run of seeded random requests, masks, acknowledges and ends of service.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int NUM_LINES = 16;
  localparam int STAGE     = 8;
  localparam int LW        = $clog2(NUM_LINES);
  localparam int CASC      = 2;   // primary input fed by the secondary stage
  localparam int ALIAS     = 9;   // secondary line that absorbs the legacy line
  localparam int NUM_RANKS = NUM_LINES - 1;

  // line sitting at priority position p (0 = strongest)
  function automatic logic [LW-1:0] line_at(input int p);
    if (p < CASC)              return LW'(p);
    else if (p < CASC + STAGE) return LW'(p - CASC + STAGE);
    else                       return LW'(p - STAGE + 1);
  endfunction
endpackage

// File: rtl/cic_route.sv
module cic_route
  import cic_pkg::*;
(
  input  logic [NUM_LINES-1:0] req_in,
  output logic [NUM_LINES-1:0] req_out
);
  always_comb begin
    req_out        = req_in;
    req_out[ALIAS] = req_in[ALIAS] | req_in[CASC];
    req_out[CASC]  = 1'b0;
  end
endmodule

// File: rtl/cic_pick.sv
module cic_pick
  import cic_pkg::*;
(
  input  logic [NUM_LINES-1:0] cand,
  output logic                 any,
  output logic [LW-1:0]        line,
  output logic [LW-1:0]        rank
);
  always_comb begin
    any  = 1'b0;
    line = '0;
    rank = '1;
    for (int p = NUM_RANKS - 1; p >= 0; p--) begin
      if (cand[line_at(p)]) begin
        any  = 1'b1;
        line = line_at(p);
        rank = LW'(p);
      end
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [7:0]           base_pri,
  input  logic [7:0]           base_sec,
  input  logic                 ack,
  input  logic                 eos,
  output logic                 cpu_int,
  output logic                 vec_valid,
  output logic [7:0]           vec
);
  localparam logic [NUM_LINES-1:0] CASC_BIT = NUM_LINES'(1) << CASC;
  localparam logic [NUM_LINES-1:0] SEC_BITS = {{STAGE{1'b1}}, {STAGE{1'b0}}};

  logic [NUM_LINES-1:0] eff_req, pend_q, pend_d, isr_q, isr_d;
  logic [NUM_LINES-1:0] cand, isr_view, ack_set, eos_clr, c_one, s_one;
  logic [LW-1:0]        c_line, c_rank, s_line, s_rank;
  logic                 c_any, s_any, take, vv_d;
  logic [7:0]           vec_d;

  cic_route u_route (.req_in(irq_req), .req_out(eff_req));

  assign cand     = pend_q & ~mask & ~CASC_BIT;
  assign isr_view = isr_q & ~CASC_BIT;

  cic_pick u_pick_pend (.cand(cand),     .any(c_any), .line(c_line), .rank(c_rank));
  cic_pick u_pick_isr  (.cand(isr_view), .any(s_any), .line(s_line), .rank(s_rank));

  assign cpu_int = c_any && (!s_any || (c_rank < s_rank));
  assign take    = ack && cpu_int;
  assign c_one   = NUM_LINES'(1) << c_line;
  assign s_one   = NUM_LINES'(1) << s_line;

  always_comb begin
    ack_set = '0;
    if (take) begin
      ack_set = c_one;
      if (c_line >= LW'(STAGE)) ack_set = ack_set | CASC_BIT;
    end
    eos_clr = '0;
    if (eos && s_any) begin
      eos_clr = s_one;
      if ((s_line >= LW'(STAGE)) && ((isr_view & SEC_BITS & ~s_one) == '0))
        eos_clr = eos_clr | CASC_BIT;
    end
    isr_d  = (isr_q & ~eos_clr) | ack_set;
    pend_d = (pend_q | eff_req) & ~(take ? c_one : '0);
    vv_d   = take;
    if (c_line < LW'(STAGE)) vec_d = {base_pri[7:3], c_line[2:0]};
    else                     vec_d = {base_sec[7:3], c_line[2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      isr_q     <= '0;
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      pend_q    <= pend_d;
      isr_q     <= isr_d;
      vec_valid <= vv_d;
      if (take) vec <= vec_d;
    end
  end

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack)); // R4
  AST_NO_VEC_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cpu_int) |=> !vec_valid); // R9
  AST_MASKED_NOT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> !mask[c_line]); // R6
  AST_TAKE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((isr_q & $past(ack_set)) == $past(ack_set))); // R7
  AST_CASC_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr_q & SEC_BITS)) |-> isr_q[CASC]); // R8
  AST_NO_LINE2_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec[2:0] != 3'd2 || vec[7:3] == base_sec[7:3])); // R5
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_req, mask;
  logic [7:0]  base_pri, base_sec;
  logic        ack, eos;
  logic        cpu_int, vec_valid;
  logic [7:0]  vec;
  int total = 0, bad = 0;
  bit done = 0;

  // bench model: device-line state only, cascade level implied
  logic [15:0] mp, mi;
  logic        mvv;
  logic [7:0]  mvec;

  always #10 clk = ~clk;

  cascade_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask(mask),
    .base_pri(base_pri), .base_sec(base_sec), .ack(ack), .eos(eos),
    .cpu_int(cpu_int), .vec_valid(vec_valid), .vec(vec));

  function automatic int rank_of(input int l);
    case (l)
      0: return 0;  1: return 1;
      3: return 10; 4: return 11; 5: return 12; 6: return 13; 7: return 14;
      2: return 99;
      default: return l - 6;
    endcase
  endfunction

  function automatic int best(input logic [15:0] v);
    int b = -1;
    for (int l = 0; l < 16; l++)
      if (v[l] && l != 2 && (b < 0 || rank_of(l) < rank_of(b))) b = l;
    return b;
  endfunction

  function automatic bit m_int();
    int c = best(mp & ~mask);
    int s = best(mi);
    if (c < 0) return 1'b0;
    return (s < 0) || (rank_of(c) < rank_of(s));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic [15:0] r, input logic a, input logic e);
    logic [15:0] np, ni, er;
    logic nvv;
    logic [7:0] nvec;
    int c, s;
    irq_req = r; ack = a; eos = e;
    er = r; if (r[2]) er[9] = 1'b1; er[2] = 1'b0;
    c = best(mp & ~mask);
    s = best(mi);
    np = mp | er; ni = mi; nvv = 1'b0; nvec = mvec;
    if (e && s >= 0) ni[s] = 1'b0;
    if (a && m_int()) begin
      np[c] = 1'b0; ni[c] = 1'b1; nvv = 1'b1;
      nvec = (c < 8) ? {base_pri[7:3], 3'(c)} : {base_sec[7:3], 3'(c - 8)};
    end
    @(posedge clk);
    mp = np; mi = ni; mvv = nvv; mvec = nvec;
    @(negedge clk);
    chk({tag, " cpu_int"}, int'(cpu_int), int'(m_int()));
    chk({tag, " vec_valid"}, int'(vec_valid), int'(mvv));
    if (mvv) chk({tag, " vec"}, int'(vec), int'(mvec));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; irq_req = '0; mask = '0; ack = 0; eos = 0;
    base_pri = 8'h23; base_sec = 8'h2D;
    mp = '0; mi = '0; mvv = 0; mvec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cpu_int", int'(cpu_int), 0);
    chk("R1 vec_valid", int'(vec_valid), 0);

    // R2 latch and hold
    step("R2", 16'h0020, 0, 0);
    chk("R2 raised", int'(cpu_int), 1);
    step("R2", 16'h0000, 0, 0);
    chk("R2 held", int'(cpu_int), 1);
    step("R4", 16'h0000, 1, 0);
    chk("R4 vec line5", int'(vec), 8'h25);
    step("R8", 16'h0000, 0, 1);

    // R3 order among 3, 8, 1
    step("R3", 16'h010A, 0, 0);
    step("R3", 16'h0000, 1, 0);
    chk("R3 first is 1", int'(vec), 8'h21);
    step("R3", 16'h0000, 0, 1);
    step("R3", 16'h0000, 1, 0);
    chk("R3 second is 8", int'(vec), 8'h28);
    step("R3", 16'h0000, 0, 1);
    step("R3", 16'h0000, 1, 0);
    chk("R3 third is 3", int'(vec), 8'h23);
    step("R3", 16'h0000, 0, 1);

    // R5 legacy line
    step("R5", 16'h0004, 0, 0);
    step("R5", 16'h0000, 1, 0);
    chk("R5 vec of line 9", int'(vec), 8'h29);
    step("R5", 16'h0000, 0, 1);

    // R6 mask
    mask = 16'h0010;
    step("R6", 16'h0010, 0, 0);
    chk("R6 masked quiet", int'(cpu_int), 0);
    step("R6", 16'h0000, 1, 0);
    chk("R6 no vector", int'(vec_valid), 0);
    mask = 16'h0000;
    step("R6", 16'h0000, 0, 0);
    chk("R6 unmasked raises", int'(cpu_int), 1);
    step("R6", 16'h0000, 1, 0);
    chk("R6 vec line4", int'(vec), 8'h24);
    step("R6", 16'h0000, 0, 1);

    // R7/R8 nesting
    step("R7", 16'h0020, 0, 0);
    step("R7", 16'h0000, 1, 0);
    step("R7", 16'h0080, 0, 0);
    chk("R7 lower held", int'(cpu_int), 0);
    step("R7", 16'h0002, 0, 0);
    chk("R7 higher nests", int'(cpu_int), 1);
    step("R7", 16'h0000, 1, 0);
    chk("R7 vec line1", int'(vec), 8'h21);
    step("R8", 16'h0000, 0, 1);
    chk("R8 line5 still blocks 7", int'(cpu_int), 0);
    step("R8", 16'h0000, 0, 1);
    chk("R8 line7 released", int'(cpu_int), 1);
    step("R8", 16'h0000, 1, 0);
    chk("R8 vec line7", int'(vec), 8'h27);
    step("R8", 16'h0000, 0, 1);

    // R7 secondary in service blocks 3..7
    step("R7", 16'h1000, 0, 0);
    step("R7", 16'h0000, 1, 0);
    step("R7", 16'h0008, 0, 0);
    chk("R7 sec blocks line3", int'(cpu_int), 0);
    step("R7", 16'h0200, 0, 0);
    chk("R7 line9 nests over 12", int'(cpu_int), 1);
    step("R7", 16'h0000, 1, 0);
    chk("R7 vec line9", int'(vec), 8'h29);
    step("R8", 16'h0000, 0, 1);
    step("R8", 16'h0000, 0, 1);
    chk("R8 line3 after secondary", int'(cpu_int), 1);
    step("R8", 16'h0000, 1, 0);
    step("R8", 16'h0000, 0, 1);

    // R9 idle acknowledge
    step("R9", 16'h0000, 1, 0);
    chk("R9 no vector", int'(vec_valid), 0);
    chk("R9 still idle", int'(cpu_int), 0);

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] r;
      r = 16'($urandom) & 16'($urandom) & 16'($urandom);
      if (($urandom % 50) == 0) mask = 16'($urandom) & 16'($urandom);
      step("R3 random", r, ($urandom % 3) == 0, ($urandom % 4) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule